// File: doc/BRIEF.md
# Grouped Vector Register File

This block holds thirty-two vector registers, each `VLEN` bits wide, and reaches them one element at a time. Each access supplies a base register, an element width code, a signed group exponent and an element index. The block treats the `2^exp` registers starting at the base as one long register. It picks the register within that group that holds the element, then cuts out the bit slice for that element. Reads are combinational. A write merges one element into its register on the rising clock edge.

Each port checks its access on its own. The base must be aligned to the group size, the group must end at or before register 31, and the index must fall inside the group. An access that fails any of these raises that port's error output. A failed read returns zero, and a failed write changes nothing. Every write that is carried out marks the vector context as dirty. That status stays set until reset or until the clear input is pulsed.

Top module: `vgrp_regfile`

## Requirements
- R1: Reset (synchronous, `rst_n` low at a clock edge) sets every bit of all 32 registers to zero, sets `ctx_status` to 2'b00 and clears `sum_dirty`.
- R2: The element width code maps 0→8, 1→16, 2→32 and 3→64 bits. Element `i` of a register occupies bits `[i*W +: W]`, so element 0 is at the least significant end. `rd_data` carries the element zero-extended to 64 bits.
- R3: The group exponent is a 3-bit two's-complement value. A value of 0 to 3 gives a group of 1, 2, 4 or 8 registers. Any negative value gives a group of one register.
- R4: With `E = VLEN/W` elements per register, index `k` selects register `base + k/E` at slot `k mod E`.
- R5: An access is illegal when `base + groupsize > 32`, when `base` is not a multiple of the group size, or when `k >= groupsize*E`. An illegal read raises `rd_err` in the same cycle and returns 0. An illegal write raises `wr_err` in the same cycle.
- R6: A write with `wr_err` high changes no register and leaves `ctx_status` and `sum_dirty` unchanged.
- R7: A legal write replaces only the addressed element. Every other bit of that register and of every other register keeps its value.
- R8: After a legal write, from the next cycle, `ctx_status` is 2'b11 and `sum_dirty` is 1.
- R9: `dirty_clr` high at an edge returns `ctx_status` to 2'b00 and `sum_dirty` to 0. If a legal write occurs in the same cycle, the write wins and the status becomes dirty.
- R10: A read of the element being written in the same cycle returns the old value. The new value is visible from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_base | input | 5 | Read base register |
| rd_sew | input | 2 | Read element width code |
| rd_lmul | input | 3 | Read group exponent, signed |
| rd_idx | input | $clog2(VLEN) | Read element index within the group |
| rd_data | output | 64 | Read element, zero-extended |
| rd_err | output | 1 | Read access illegal |
| wr_en | input | 1 | Write request |
| wr_base | input | 5 | Write base register |
| wr_sew | input | 2 | Write element width code |
| wr_lmul | input | 3 | Write group exponent, signed |
| wr_idx | input | $clog2(VLEN) | Write element index within the group |
| wr_data | input | 64 | Write element, low W bits used |
| wr_err | output | 1 | Write access illegal |
| dirty_clr | input | 1 | Clear the context status |
| ctx_status | output | 2 | Context status, 2'b11 when dirty |
| sum_dirty | output | 1 | Summary dirty flag |

## Verification
The bench first runs directed cases. One writes ascending values across an eight- and a four-register group, which shows whether index carries reach the next register and whether slots land in the correct place. Another reads the same data back with a different width and base, which exposes slice-position and zero-extension faults. Misaligned, overflowing and out-of-range accesses test the error rule and confirm that a refused write leaves data and status alone. Same-cycle read/write and clear/write pairs test the ordering rules. A long random run, with reads often aimed at the write address, is then compared on every clock against a behavioural model.

// File: rtl/vrf_pkg.sv
// Package: shared types and helpers for the grouped vector register file.
// Assumes element widths of 8..64 bits encoded in two bits.
package vrf_pkg;

    localparam int NREG = 32;
    localparam int REGW = 5;
    localparam int ELEN = 64;

    typedef enum logic [1:0] {
        EW8  = 2'd0,
        EW16 = 2'd1,
        EW32 = 2'd2,
        EW64 = 2'd3
    } ew_e;

    localparam logic [1:0] CTX_CLEAN = 2'b00;
    localparam logic [1:0] CTX_DIRTY = 2'b11;

    // Low-order ones covering one element of the given width.
    function automatic logic [ELEN-1:0] ew_mask(ew_e ew);
        case (ew)
            EW8:     ew_mask = 64'h0000_0000_0000_00FF;
            EW16:    ew_mask = 64'h0000_0000_0000_FFFF;
            EW32:    ew_mask = 64'h0000_0000_FFFF_FFFF;
            default: ew_mask = 64'hFFFF_FFFF_FFFF_FFFF;
        endcase
    endfunction

endpackage

// File: rtl/vrf_group_map.sv
// Module: vrf_group_map
// Turns (base, width, group exponent, index) into a physical register
// number and a bit offset, and flags illegal groups.
// Assumes VLEN is a power of two and at least 64.
module vrf_group_map
    import vrf_pkg::*;
#(
    parameter int VLEN = 128,
    localparam int IDXW = $clog2(VLEN)
) (
    input  logic [REGW-1:0]  base,
    input  ew_e              ew,
    input  logic [2:0]       gexp,
    input  logic [IDXW-1:0]  idx,
    output logic [REGW-1:0]  reg_sel,
    output logic [IDXW-1:0]  bit_off,
    output logic             illegal
);

    logic [1:0]      gpow;
    logic [5:0]      gsize;
    logic [IDXW-1:0] reg_ofs;
    logic [IDXW-1:0] slot;
    logic            over;
    logic            misalign;
    logic            beyond;
    int              epr_log;

    // Decode group size, split the index, and evaluate the legality rules.
    always_comb begin
        gpow     = gexp[2] ? 2'd0 : gexp[1:0];
        gsize    = 6'd1 << gpow;
        epr_log  = IDXW - 3 - int'(ew);
        reg_ofs  = idx >> epr_log;
        slot     = idx - (reg_ofs << epr_log);
        bit_off  = slot << (3 + int'(ew));
        over     = ({1'b0, base} + gsize) > 6'd32;
        misalign = (base & (gsize[REGW-1:0] - 5'd1)) != 5'd0;
        beyond   = int'(reg_ofs) >= int'(gsize);
        illegal  = over | misalign | beyond;
        reg_sel  = base + reg_ofs[REGW-1:0];
    end

endmodule

// File: rtl/vrf_elem_read.sv
// Module: vrf_elem_read
// Extracts one element from a register row and zero-extends it.
// Assumes bit_off is element-aligned and the row is at least 64 bits.
module vrf_elem_read
    import vrf_pkg::*;
#(
    parameter int VLEN = 128,
    localparam int IDXW = $clog2(VLEN)
) (
    input  logic [VLEN-1:0] row,
    input  ew_e             ew,
    input  logic [IDXW-1:0] bit_off,
    input  logic            illegal,
    output logic [ELEN-1:0] data
);

    logic [VLEN-1:0] shifted;

    // Shift the element down to bit 0, then mask to its width.
    always_comb begin
        shifted = row >> bit_off;
        data    = illegal ? '0 : (shifted[ELEN-1:0] & ew_mask(ew));
    end

endmodule

// File: rtl/vrf_elem_merge.sv
// Module: vrf_elem_merge
// Builds the new row for a single-element write: old bits outside the
// element are kept, bits inside come from the write data.
module vrf_elem_merge
    import vrf_pkg::*;
#(
    parameter int VLEN = 128,
    localparam int IDXW = $clog2(VLEN)
) (
    input  logic [VLEN-1:0] old_row,
    input  ew_e             ew,
    input  logic [IDXW-1:0] bit_off,
    input  logic [ELEN-1:0] wdata,
    output logic [VLEN-1:0] new_row
);

    logic [VLEN-1:0] hole;
    logic [VLEN-1:0] ins;

    // Align a mask and the data to the element, then splice.
    always_comb begin
        hole    = VLEN'(ew_mask(ew)) << bit_off;
        ins     = VLEN'(wdata & ew_mask(ew)) << bit_off;
        new_row = (old_row & ~hole) | ins;
    end

endmodule

// File: rtl/vrf_ctx_status.sv
// Module: vrf_ctx_status
// Holds the two-bit context status and the summary dirty flag.
// A set request has priority over a clear request.
module vrf_ctx_status
    import vrf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       set_dirty,
    input  logic       clr_dirty,
    output logic [1:0] status,
    output logic       summary
);

    // Update the status on a write, a clear or a reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status  <= CTX_CLEAN;
            summary <= 1'b0;
        end else if (set_dirty) begin
            status  <= CTX_DIRTY;
            summary <= 1'b1;
        end else if (clr_dirty) begin
            status  <= CTX_CLEAN;
            summary <= 1'b0;
        end
    end

endmodule

// File: rtl/vgrp_regfile.sv
// Module: vgrp_regfile
// Thirty-two VLEN-bit vector registers with element-granular access over
// register groups. One combinational read port, one clocked write port.
// Assumes VLEN is a power of two, at least 64.
module vgrp_regfile
    import vrf_pkg::*;
#(
    parameter int VLEN = 128,
    localparam int IDXW = $clog2(VLEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [4:0]       rd_base,
    input  logic [1:0]       rd_sew,
    input  logic [2:0]       rd_lmul,
    input  logic [IDXW-1:0]  rd_idx,
    output logic [63:0]      rd_data,
    output logic             rd_err,
    input  logic             wr_en,
    input  logic [4:0]       wr_base,
    input  logic [1:0]       wr_sew,
    input  logic [2:0]       wr_lmul,
    input  logic [IDXW-1:0]  wr_idx,
    input  logic [63:0]      wr_data,
    output logic             wr_err,
    input  logic             dirty_clr,
    output logic [1:0]       ctx_status,
    output logic             sum_dirty
);

    logic [VLEN-1:0]      regs [NREG];
    logic [NREG*VLEN-1:0] mem_flat;
    logic [REGW-1:0]      rd_reg;
    logic [REGW-1:0]      wr_reg;
    logic [IDXW-1:0]      rd_off;
    logic [IDXW-1:0]      wr_off;
    logic [VLEN-1:0]      merged;
    logic                 wr_go;

    vrf_group_map #(.VLEN(VLEN)) u_rmap (
        .base    (rd_base),
        .ew      (ew_e'(rd_sew)),
        .gexp    (rd_lmul),
        .idx     (rd_idx),
        .reg_sel (rd_reg),
        .bit_off (rd_off),
        .illegal (rd_err)
    );

    vrf_group_map #(.VLEN(VLEN)) u_wmap (
        .base    (wr_base),
        .ew      (ew_e'(wr_sew)),
        .gexp    (wr_lmul),
        .idx     (wr_idx),
        .reg_sel (wr_reg),
        .bit_off (wr_off),
        .illegal (wr_err)
    );

    vrf_elem_read #(.VLEN(VLEN)) u_rd (
        .row     (regs[rd_reg]),
        .ew      (ew_e'(rd_sew)),
        .bit_off (rd_off),
        .illegal (rd_err),
        .data    (rd_data)
    );

    vrf_elem_merge #(.VLEN(VLEN)) u_merge (
        .old_row (regs[wr_reg]),
        .ew      (ew_e'(wr_sew)),
        .bit_off (wr_off),
        .wdata   (wr_data),
        .new_row (merged)
    );

    assign wr_go = wr_en & ~wr_err;

    vrf_ctx_status u_ctx (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_dirty (wr_go),
        .clr_dirty (dirty_clr),
        .status    (ctx_status),
        .summary   (sum_dirty)
    );

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        logic [VLEN-1:0] q;

        // Storage of one register: cleared by reset, loaded when addressed.
        always_ff @(posedge clk) begin
            if (!rst_n)
                q <= '0;
            else if (wr_go && (wr_reg == REGW'(g)))
                q <= merged;
        end

        assign regs[g] = q;
    end

    // Flat view of the whole array, used by the bound checker.
    always_comb begin
        for (int g = 0; g < NREG; g++)
            mem_flat[g*VLEN +: VLEN] = regs[g];
    end

endmodule

// File: rtl/vrf_checker.sv
// Module: vrf_checker
// Temporal properties of the grouped register file, bound to the top.
module vrf_checker #(
    parameter int VLEN = 128
) (
    input logic              clk,
    input logic              rst_n,
    input logic [4:0]        rd_base,
    input logic [1:0]        rd_sew,
    input logic [2:0]        rd_lmul,
    input logic [63:0]       rd_data,
    input logic              rd_err,
    input logic              wr_en,
    input logic              wr_err,
    input logic              dirty_clr,
    input logic [1:0]        ctx_status,
    input logic              sum_dirty,
    input logic [32*VLEN-1:0] mem_flat
);

    p_reset_clean_r1: assert property (@(posedge clk)
        !rst_n |=> (ctx_status == 2'b00 && !sum_dirty));

    p_byte_zext_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sew == 2'd0) |-> (rd_data[63:8] == 56'd0));

    p_misalign_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_lmul == 3'd1 && rd_base[0]) |-> rd_err);

    p_err_reads_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_err |-> (rd_data == 64'd0));

    p_no_write_keeps_regs_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en || wr_err) |=> $stable(mem_flat));

    p_err_keeps_status_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_err && !dirty_clr) |=> $stable(ctx_status));

    p_write_dirties_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_err) |=> (ctx_status == 2'b11 && sum_dirty));

    p_clear_cleans_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (dirty_clr && !(wr_en && !wr_err)) |=> (ctx_status == 2'b00 && !sum_dirty));

endmodule

bind vgrp_regfile vrf_checker #(.VLEN(VLEN)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_base    (rd_base),
    .rd_sew     (rd_sew),
    .rd_lmul    (rd_lmul),
    .rd_data    (rd_data),
    .rd_err     (rd_err),
    .wr_en      (wr_en),
    .wr_err     (wr_err),
    .dirty_clr  (dirty_clr),
    .ctx_status (ctx_status),
    .sum_dirty  (sum_dirty),
    .mem_flat   (mem_flat)
);

// File: tb/sim_vgrp_regfile.sv
module sim_vgrp_regfile;

    localparam int VLEN  = 128;
    localparam int IDXW  = $clog2(VLEN);
    localparam int CLK_P = 10;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [4:0]      rd_base, wr_base;
    logic [1:0]      rd_sew, wr_sew;
    logic [2:0]      rd_lmul, wr_lmul;
    logic [IDXW-1:0] rd_idx, wr_idx;
    logic [63:0]     rd_data, wr_data;
    logic            rd_err, wr_err, wr_en, dirty_clr, sum_dirty;
    logic [1:0]      ctx_status;

    logic [VLEN-1:0] m [32];
    logic [1:0]      m_stat;
    logic            m_sum;
    int nchk = 0;
    int nfail = 0;

    always #(CLK_P/2) clk = ~clk;

    vgrp_regfile #(.VLEN(VLEN)) u0 (.*);

    // Model: legality and placement with plain integer arithmetic.
    function automatic bit legal(int base, int sew, logic [2:0] lm, int k,
                                 output int r, output int off);
        int l = $signed(lm);
        int g = (l < 0) ? 1 : (1 << l);
        int w = 8 << sew;
        int e = VLEN / w;
        r = base + k / e;
        off = (k % e) * w;
        return !((base + g > 32) || (base % g != 0) || (k >= g * e));
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One cycle: compare outputs against the model, then advance the model.
    task automatic step(string req);
        int r, off, w;
        bit ok;
        logic [63:0] exp;
        #1;
        w = 8 << rd_sew;
        ok = legal(rd_base, rd_sew, rd_lmul, rd_idx, r, off);
        exp = 64'd0;
        if (ok) for (int b = 0; b < w; b++) exp[b] = m[r][off + b];
        chk({req, " rd_err"}, 64'(rd_err), 64'(!ok));
        chk({req, " rd_data"}, rd_data, exp);
        chk({req, " wr_err"}, 64'(wr_err),
            64'(!legal(wr_base, wr_sew, wr_lmul, wr_idx, r, off)));
        chk({req, " status"}, {61'd0, m_sum, m_stat}, {61'd0, sum_dirty, ctx_status});
        @(posedge clk);
        w = 8 << wr_sew;
        if (wr_en && legal(wr_base, wr_sew, wr_lmul, wr_idx, r, off)) begin
            for (int b = 0; b < w; b++) m[r][off + b] = wr_data[b];
            m_stat = 2'b11;
            m_sum = 1'b1;
        end else if (dirty_clr) begin
            m_stat = 2'b00;
            m_sum = 1'b0;
        end
        @(negedge clk);
    endtask

    task automatic setrd(int b, int s, int l, int k);
        rd_base = 5'(b); rd_sew = 2'(s); rd_lmul = 3'(l); rd_idx = IDXW'(k);
    endtask

    task automatic setwr(bit en, int b, int s, int l, int k, logic [63:0] d);
        wr_en = en; wr_base = 5'(b); wr_sew = 2'(s); wr_lmul = 3'(l);
        wr_idx = IDXW'(k); wr_data = d;
    endtask

    initial begin
        #(CLK_P * 200000);
        nchk++;
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) m[i] = '0;
        m_stat = 2'b00;
        m_sum = 1'b0;
        rst_n = 1'b0;
        dirty_clr = 1'b0;
        setrd(0, 0, 0, 0);
        setwr(0, 0, 0, 0, 0, 64'd0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: every register reads zero, status clean.
        for (int i = 0; i < 32; i++) begin
            setrd(i, 3, 0, 1);
            step("R1");
        end

        // R6: illegal writes (overflow, misalign) leave data and status alone.
        setwr(1, 30, 0, 2, 0, 64'hFF);
        setrd(28, 0, 2, 0);
        step("R6");
        setwr(1, 2, 1, 2, 3, 64'hBEEF);
        setrd(2, 1, 0, 3);
        step("R6");
        setwr(0, 0, 0, 0, 0, 64'd0);
        setrd(30, 0, 0, 0);
        step("R6");

        // R2/R7/R8: single byte at element 0 of v1, neighbours stay zero.
        setwr(1, 1, 0, 0, 0, 64'hFFFF_FFFF_FFFF_FFA5);
        setrd(1, 0, 0, 0);
        step("R10");
        setwr(0, 0, 0, 0, 0, 64'd0);
        step("R2");
        setrd(1, 0, 0, 1);
        step("R7");
        setrd(1, 3, 0, 0);
        step("R2");

        // R4: ascending 32-bit values across a four-register group at v8.
        for (int k = 0; k < 16; k++) begin
            setwr(1, 8, 2, 2, k, 64'hA000_0000 + 64'(k));
            setrd(8, 2, 2, (k + 15) % 16);
            step("R4");
        end
        setwr(0, 0, 0, 0, 0, 64'd0);
        setrd(9, 2, 0, 1);
        step("R4");
        setrd(11, 3, 0, 1);
        step("R4");
        setrd(8, 2, 2, 16);
        step("R5");

        // R4: eight-register group of bytes at v16, carries into v23.
        setwr(1, 16, 0, 3, 127, 64'h5C);
        setrd(23, 0, 0, 15);
        step("R4");
        setwr(0, 0, 0, 0, 0, 64'd0);
        step("R4");

        // R3: negative exponent is a single register; odd base allowed.
        setwr(1, 3, 1, -2, 7, 64'h1234);
        setrd(3, 1, -1, 7);
        step("R3");
        setwr(1, 3, 1, -3, 8, 64'h9999);
        step("R3");
        setwr(0, 0, 0, 0, 0, 64'd0);
        setrd(3, 1, -4, 7);
        step("R3");
        setrd(5, 0, 1, 0);
        step("R5");
        setrd(24, 3, 3, 15);
        step("R5");

        // R9: clear, then clear together with a write (write wins).
        dirty_clr = 1'b1;
        step("R9");
        dirty_clr = 1'b0;
        step("R9");
        dirty_clr = 1'b1;
        setwr(1, 4, 3, 0, 1, 64'hDEAD_BEEF_0BAD_F00D);
        setrd(4, 3, 0, 1);
        step("R10");
        dirty_clr = 1'b0;
        setwr(0, 0, 0, 0, 0, 64'd0);
        step("R9");

        // Random traffic against the model.
        for (int n = 0; n < 3000; n++) begin
            int b = int'($urandom_range(0, 31));
            int s = int'($urandom_range(0, 3));
            int l = int'($urandom_range(0, 7));
            int k = int'($urandom_range(0, VLEN - 1));
            if ($urandom_range(0, 3) != 0) begin
                b = b & ~((1 << (l > 3 ? 0 : l)) - 1);
                if (l <= 3) b = b % (33 - (1 << l));
                b = b & ~((1 << (l > 3 ? 0 : l)) - 1);
                k = k % (((l > 3) ? 1 : (1 << l)) * (VLEN / (8 << s)));
            end
            setwr($urandom_range(0, 1) == 1, b, s, l, k,
                  {$urandom(), $urandom()});
            if ($urandom_range(0, 1) == 1)
                setrd(b, s, l, k);
            else
                setrd(int'($urandom_range(0, 31)), int'($urandom_range(0, 3)),
                      0, int'($urandom_range(0, 7)));
            dirty_clr = ($urandom_range(0, 15) == 0);
            step("R7");
        end

        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

endmodule